// File: doc/BRIEF.md
# Sixteen-Bit Shift Unit with Status Flags

This block performs one shift per issued operation on a 16-bit word. It supports a left shift, a logical right shift and an arithmetic right shift. It produces the shifted word and a new set of six status flags: carry, overflow, sign, zero, parity and auxiliary carry. The carry and overflow rules follow the conventions of common general-purpose processors. These rules stay defined when the shift count reaches or passes the word width.

An execution pipeline presents the operand, a count, a 2-bit operation code and the current flags, and raises `op_valid_i` for one cycle. At the next clock edge the block registers its outputs. The result, the flags and a one-cycle write-enable then appear on the outputs. The write-enable tells the register file and the flag register whether to commit anything. A zero masked count or the reserved operation code commits nothing: the outputs carry the incoming word and flags back unchanged.

Top module: `shf_unit`

## Requirements
- R1: Only the low 5 bits of `count_i` form the shift amount; bits 7..5 have no effect on any output.
- R2: With a masked amount of zero, `wr_en_o` stays low, `result_o` equals the operand and `flags_o` equals `flags_i`. The flag bit positions are [5]=OF, [4]=SF, [3]=ZF, [2]=AF, [1]=PF, [0]=CF.
- R3: Operation code 2'b00 is a left shift. For an amount n from 1 to 16 the result is the operand shifted left by n, CF is operand bit (16−n), and OF is CF XOR result bit 15.
- R4: A left shift with an amount from 17 to 31 gives a zero result and clears both CF and OF.
- R5: Operation code 2'b01 is a logical right shift. CF is operand bit (n−1), and CF is 0 for n above 16. OF is result bit 15 XOR result bit 14.
- R6: Operation code 2'b10 is an arithmetic right shift. It fills vacated bits with the sign bit and CF is bit (n−1) of the sign-extended operand. For n of 16 or more the result is all sign bits and CF equals the sign bit. OF is always 0.
- R7: For every executed shift, SF is result bit 15. ZF is set when the result is zero. PF is set when result bits 7..0 hold an even number of ones.
- R8: Every executed shift (nonzero amount, code other than 2'b11) clears AF and pulses `wr_en_o` high for exactly one cycle.
- R9: Operation code 2'b11 is reserved. It behaves like a zero amount: no write, and the operand and flags pass through.
- R10: Outputs update only on the clock edge that samples `op_valid_i` high, and hold otherwise. Reset clears the result, the flags and `wr_en_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid_i | input | 1 | Issue strobe for one operation |
| op_sel_i | input | 2 | 00 left, 01 logical right, 10 arithmetic right, 11 reserved |
| operand_i | input | 16 | Word to shift |
| count_i | input | 8 | Shift count; low 5 bits used |
| flags_i | input | 6 | Current flags {OF,SF,ZF,AF,PF,CF} |
| result_o | output | 16 | Shifted word, registered |
| wr_en_o | output | 1 | One-cycle commit strobe |
| flags_o | output | 6 | Updated flags {OF,SF,ZF,AF,PF,CF} |

## Verification
A wrong stage select or fill bit inside the barrel network shows up as a wrong `result_o` or CF in the cycle right after the issuing edge. No later state carries the error forward. A faulty execute decision shows in the same cycle, in two ways: `wr_en_o` asserts on a zero amount or the reserved code, or the incoming flags are replaced when they should pass through. A faulty hold shows as outputs that drift during idle cycles after an operation.

// File: rtl/shf_pkg.sv
package shf_pkg;

   typedef enum logic [1:0] {
      SHF_LEFT  = 2'b00,
      SHF_RIGHT = 2'b01,
      SHF_ARITH = 2'b10,
      SHF_RSVD  = 2'b11
   } shf_op_e;

   // bit 5 down to bit 0
   typedef struct packed {
      logic of;
      logic sf;
      logic zf;
      logic af;
      logic pf;
      logic cf;
   } shf_flags_t;

endpackage

// File: rtl/shf_barrel.sv
// Logarithmic right shifter over a double-width window with a selectable fill bit.
module shf_barrel #(
   parameter int WIDTH    = 16,
   parameter int CNT_BITS = 5
) (
   input  logic [2*WIDTH-1:0] din,
   input  logic               fill,
   input  logic [CNT_BITS-1:0] amt,
   output logic [2*WIDTH-1:0] dout
);
   localparam int DW = 2 * WIDTH;

   logic [DW-1:0] stage [CNT_BITS+1];

   assign stage[0] = din;

   for (genvar i = 0; i < CNT_BITS; i++) begin : g_stage
      localparam int S = 1 << i;
      assign stage[i+1] = amt[i] ? {{S{fill}}, stage[i][DW-1:S]} : stage[i];
   end

   assign dout = stage[CNT_BITS];

endmodule

// File: rtl/shf_datapath.sv
module shf_datapath
   import shf_pkg::*;
#(
   parameter int WIDTH    = 16,
   parameter int CNT_BITS = 5
) (
   input  shf_op_e             op,
   input  logic [WIDTH-1:0]    operand,
   input  logic [CNT_BITS-1:0] amt,
   output logic [WIDTH-1:0]    res,
   output logic                cf,
   output logic                of
);
   localparam int DW = 2 * WIDTH;

   logic              is_left;
   logic              is_arith;
   logic [WIDTH-1:0]  op_rev;
   logic [WIDTH-1:0]  hi;
   logic [WIDTH-1:0]  hi_rev;
   logic [DW-1:0]     window;
   logic [DW-1:0]     shifted;
   logic              unused_low;

   assign is_left  = (op == SHF_LEFT);
   assign is_arith = (op == SHF_ARITH);

   for (genvar j = 0; j < WIDTH; j++) begin : g_rev
      assign op_rev[j] = operand[WIDTH-1-j];
      assign hi_rev[j] = hi[WIDTH-1-j];
   end

   // left shifts run through the same right shifter on the mirrored word
   assign window = {(is_left ? op_rev : operand), {WIDTH{1'b0}}};

   shf_barrel #(.WIDTH(WIDTH), .CNT_BITS(CNT_BITS)) u_barrel (
      .din  (window),
      .fill (is_arith & operand[WIDTH-1]),
      .amt  (amt),
      .dout (shifted)
   );

   assign hi         = shifted[DW-1:WIDTH];
   assign res        = is_left ? hi_rev : hi;
   assign cf         = shifted[WIDTH-1];
   assign unused_low = ^shifted[WIDTH-2:0];

   always_comb begin
      unique case (op)
         SHF_LEFT:  of = cf ^ res[WIDTH-1];
         SHF_RIGHT: of = res[WIDTH-1] ^ res[WIDTH-2];
         default:   of = 1'b0;
      endcase
   end

endmodule

// File: rtl/shf_status.sv
module shf_status #(
   parameter int WIDTH     = 16,
   parameter int PAR_BITS  = 8
) (
   input  logic [WIDTH-1:0] res,
   output logic             sf,
   output logic             zf,
   output logic             pf
);
   assign sf = res[WIDTH-1];
   assign zf = (res == '0);
   assign pf = ~^res[PAR_BITS-1:0];
endmodule

// File: rtl/shf_unit.sv
module shf_unit
   import shf_pkg::*;
#(
   parameter int WIDTH       = 16,
   parameter int CNT_BITS    = 5,
   parameter int CNT_IN_BITS = 8,
   parameter int PAR_BITS    = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   op_valid_i,
   input  logic [1:0]             op_sel_i,
   input  logic [WIDTH-1:0]       operand_i,
   input  logic [CNT_IN_BITS-1:0] count_i,
   input  logic [5:0]             flags_i,
   output logic [WIDTH-1:0]       result_o,
   output logic                   wr_en_o,
   output logic [5:0]             flags_o
);
   if ((1 << CNT_BITS) > 2 * WIDTH) begin : g_bad_cnt
      $error("shf_unit: shift amount range exceeds the double-width window");
   end
   if (CNT_IN_BITS <= CNT_BITS) begin : g_bad_in
      $error("shf_unit: count input must be wider than the shift amount");
   end
   if (PAR_BITS > WIDTH || WIDTH < 2) begin : g_bad_w
      $error("shf_unit: width or parity span out of range");
   end

   shf_op_e             op;
   logic [CNT_BITS-1:0] amt;
   logic                exec;
   logic [WIDTH-1:0]    dp_res;
   logic                dp_cf, dp_of;
   logic                st_sf, st_zf, st_pf;
   logic                unused_cnt_hi;
   shf_flags_t          flags_q;
   logic [WIDTH-1:0]    result_q;
   logic                wr_q;

   assign op            = shf_op_e'(op_sel_i);
   assign amt           = count_i[CNT_BITS-1:0];
   assign unused_cnt_hi = ^count_i[CNT_IN_BITS-1:CNT_BITS];
   assign exec          = (amt != '0) && (op != SHF_RSVD);

   shf_datapath #(.WIDTH(WIDTH), .CNT_BITS(CNT_BITS)) u_dp (
      .op      (op),
      .operand (operand_i),
      .amt     (amt),
      .res     (dp_res),
      .cf      (dp_cf),
      .of      (dp_of)
   );

   shf_status #(.WIDTH(WIDTH), .PAR_BITS(PAR_BITS)) u_st (
      .res (dp_res),
      .sf  (st_sf),
      .zf  (st_zf),
      .pf  (st_pf)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result_q <= '0;
         flags_q  <= '0;
         wr_q     <= 1'b0;
      end else if (op_valid_i) begin
         if (exec) begin
            result_q <= dp_res;
            flags_q  <= '{of: dp_of, sf: st_sf, zf: st_zf, af: 1'b0, pf: st_pf, cf: dp_cf};
            wr_q     <= 1'b1;
         end else begin
            result_q <= operand_i;
            flags_q  <= shf_flags_t'(flags_i);
            wr_q     <= 1'b0;
         end
      end else begin
         wr_q <= 1'b0;
      end
   end

   assign result_o = result_q;
   assign wr_en_o  = wr_q;
   assign flags_o  = flags_q;

   // ---------------- assertions ----------------
   assert_zero_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid_i && amt == '0) |=>
         (!wr_en_o && result_o == $past(operand_i) && flags_o == $past(flags_i)));

   assert_big_left_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid_i && op == SHF_LEFT && int'(amt) > WIDTH) |=>
         (result_o == '0 && !flags_o[0] && !flags_o[5]));

   assert_big_right_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid_i && op == SHF_RIGHT && int'(amt) > WIDTH) |=>
         (result_o == '0 && !flags_o[0]));

   assert_arith_of_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid_i && op == SHF_ARITH && amt != '0) |=> !flags_o[5]);

   assert_af_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid_i && amt != '0 && op != SHF_RSVD) |=> (wr_en_o && !flags_o[2]));

   assert_rsvd_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid_i && op == SHF_RSVD) |=> !wr_en_o);

   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid_i |=> (!wr_en_o && $stable(result_o) && $stable(flags_o)));

endmodule

// File: tb/sim_shf_unit.sv
`timescale 1ns/1ps
module sim_shf_unit;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        op_valid_i;
   logic [1:0]  op_sel_i;
   logic [15:0] operand_i;
   logic [7:0]  count_i;
   logic [5:0]  flags_i;
   logic [15:0] result_o;
   logic        wr_en_o;
   logic [5:0]  flags_o;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   shf_unit u0 (
      .clk, .rst_n, .op_valid_i, .op_sel_i, .operand_i, .count_i, .flags_i,
      .result_o, .wr_en_o, .flags_o
   );

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // independent model from the requirement text
   task automatic model(input logic [1:0] sel, input logic [15:0] op, input logic [7:0] cnt,
                        input logic [5:0] fin, output logic [15:0] res,
                        output logic we, output logic [5:0] fo);
      int c;
      int v;
      logic cf, of;
      c = int'(cnt) % 32;
      cf = 1'b0; of = 1'b0;
      if (c == 0 || sel == 2'b11) begin
         res = op; we = 1'b0; fo = fin;
         return;
      end
      we = 1'b1;
      if (sel == 2'b00) begin
         v   = int'(op) * (1 << c);
         res = (c <= 16) ? v[15:0] : 16'h0;
         cf  = (c <= 16) ? op[16-c] : 1'b0;
         of  = cf ^ res[15];
      end else if (sel == 2'b01) begin
         v   = int'(op) / (1 << c);
         res = v[15:0];
         cf  = (c <= 16) ? op[c-1] : 1'b0;
         of  = res[15] ^ res[14];
      end else begin
         v   = int'($signed(op)) >>> c;
         res = v[15:0];
         cf  = (c <= 16) ? op[c-1] : op[15];
         of  = 1'b0;
      end
      fo = {of, res[15], (res == 16'h0), 1'b0, ~^res[7:0], cf};
   endtask

   task automatic run_op(string tag, input logic [1:0] sel, input logic [15:0] op,
                         input logic [7:0] cnt, input logic [5:0] fin);
      logic [15:0] er; logic ew; logic [5:0] ef;
      @(negedge clk);
      op_valid_i = 1'b1; op_sel_i = sel; operand_i = op; count_i = cnt; flags_i = fin;
      @(posedge clk); #1;
      op_valid_i = 1'b0;
      model(sel, op, cnt, fin, er, ew, ef);
      check({tag, " result"}, 32'(result_o), 32'(er));
      check({tag, " wr_en"},  32'(wr_en_o),  32'(ew));
      check({tag, " flags"},  32'(flags_o),  32'(ef));
   endtask

   task automatic test_reset();
      rst_n = 1'b0; op_valid_i = 1'b0; op_sel_i = '0; operand_i = '0; count_i = '0; flags_i = '0;
      repeat (3) @(posedge clk);
      #1;
      check("R10 reset result", 32'(result_o), 0);
      check("R10 reset wr_en",  32'(wr_en_o),  0);
      check("R10 reset flags",  32'(flags_o),  0);
      @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic test_left();
      run_op("R3 shl 1",   2'b00, 16'h8001, 8'd1,  6'h00);
      run_op("R3 shl 4",   2'b00, 16'h1234, 8'd4,  6'h3F);
      run_op("R3 shl 15",  2'b00, 16'h0003, 8'd15, 6'h00);
      run_op("R3 shl 16",  2'b00, 16'h0001, 8'd16, 6'h00);
      run_op("R4 shl 17",  2'b00, 16'hFFFF, 8'd17, 6'h21);
      run_op("R4 shl 31",  2'b00, 16'hFFFF, 8'd31, 6'h00);
   endtask

   task automatic test_right();
      run_op("R5 shr 1",   2'b01, 16'h8001, 8'd1,  6'h00);
      run_op("R5 shr 5",   2'b01, 16'hF0F0, 8'd5,  6'h00);
      run_op("R5 shr 16",  2'b01, 16'h8000, 8'd16, 6'h00);
      run_op("R5 shr 17",  2'b01, 16'hFFFF, 8'd17, 6'h3F);
   endtask

   task automatic test_arith();
      run_op("R6 sar 3",   2'b10, 16'h8010, 8'd3,  6'h20);
      run_op("R6 sar 7",   2'b10, 16'h7F80, 8'd7,  6'h00);
      run_op("R6 sar 16",  2'b10, 16'h8000, 8'd16, 6'h00);
      run_op("R6 sar 20",  2'b10, 16'hC000, 8'd20, 6'h00);
      run_op("R6 sar pos 20", 2'b10, 16'h4000, 8'd20, 6'h3F);
   endtask

   task automatic test_status();
      run_op("R7 zero result", 2'b01, 16'h0001, 8'd1, 6'h00);
      run_op("R7 odd parity",  2'b00, 16'h0001, 8'd0 + 8'd2, 6'h00);
      run_op("R8 af clear",    2'b00, 16'h00FF, 8'd8, 6'h04);
   endtask

   task automatic test_mask_and_rsvd();
      run_op("R1 mask 0x21",   2'b00, 16'h4001, 8'h21, 6'h00);
      run_op("R1 mask 0xE3",   2'b01, 16'hABCD, 8'hE3, 6'h00);
      run_op("R2 mask 0x20",   2'b00, 16'h1234, 8'h20, 6'h15);
      run_op("R2 count 0",     2'b10, 16'h8765, 8'h00, 6'h2A);
      run_op("R9 reserved",    2'b11, 16'h5A5A, 8'd3,  6'h13);
   endtask

   task automatic test_hold();
      logic [15:0] r; logic [5:0] f;
      run_op("R10 setup", 2'b00, 16'h0F0F, 8'd2, 6'h00);
      r = result_o; f = flags_o;
      @(negedge clk); operand_i = 16'hFFFF; count_i = 8'd1; flags_i = 6'h3F;
      repeat (3) @(posedge clk);
      #1;
      check("R8 wr_en pulse ends", 32'(wr_en_o), 0);
      check("R10 hold result", 32'(result_o), 32'(r));
      check("R10 hold flags",  32'(flags_o),  32'(f));
   endtask

   initial begin
      test_reset();
      test_left();
      test_right();
      test_arith();
      test_status();
      test_mask_and_rsvd();
      test_hold();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #2000000;
      if (!done) begin
         done = 1'b1;
         errors++; checks++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule